// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the start-up training of a multi-lane serial display link. On a start pulse it programs the link rate and the lane count into the receiver. It then runs clock recovery with the first training pattern and channel equalisation with the second. Between attempts it reads the receiver's drive-level requests and raises one shared drive level for all lanes. Every register access to the receiver goes through a request/done handshake toward a separate sideband sequencer. That sequencer carries out the actual transfer and returns the read bytes.

Training always ends by disabling the training pattern. If the link did not train and the fast rate was in use, the block drops to the slow rate and runs the whole sequence again. The block also drives local copies of the active pattern, the committed drive level and the rate, for the transmitter. It masks the hot-plug interrupt while training is in progress.

Top module: `lt_seq`

## Requirements
- R1: After reset the block is idle: `hp_irq_mask`, `sb_req`, `done`, `trained` and `tx_pattern` are 0. `hp_irq_mask` is 1 from the cycle after `start` until training ends, and it is 0 in the `done` cycle.
- R2: Each pass first writes the rate code to address 0x100, as 1 byte: 0x0A when fast, 0x06 when slow. The very next request writes the lane-count byte to 0x101. That byte holds the lane count (1, 2 or 4; any other `cap_lanes` value means 4) in bits [2:0]. Bit 7 is set only when `sink_rev` >= 0x11 and `sink_enh` is 1.
- R3: Clock recovery first writes 1 to 0x102. Its first drive commit is 0. Each commit writes 4 bytes to 0x103, one byte per lane: the drive byte for an active lane and 0 for an inactive one. After each commit the block waits `CR_WAIT` cycles and then reads 2 status bytes at 0x202. Lane k's status nibble sits at bits [4k+3:4k]. Nibble bit 0 means clock recovered. The phase passes when every active lane shows bit 0.
- R4: A try counter restarts whenever the committed swing (drive bits [1:0]) differs from the previous status read. Clock recovery fails after `CR_TRIES` reads at one swing. It also fails when a read does not pass while the committed drive has its swing-limit flag (bit 2) set.
- R5: An adjustment reads 2 bytes at 0x206, where each lane's nibble holds the swing in [1:0] and the pre-emphasis in [3:2]. The block takes the largest swing and the largest pre-emphasis over the active lanes only. A swing that is >= `max_swing` becomes `max_swing` with bit 2 set, and pre-emphasis is clamped the same way against `max_pre`. The new drive byte is pre<<3 | swing.
- R6: Equalisation writes 2 to 0x102, waits `EQ_WAIT` cycles and reads 3 bytes at 0x202, for at most `EQ_TRIES` reads. A read succeeds when byte 2 bit 0 is set and every active lane has nibble bits 0, 1 and 2 set. A read that shows a lost clock recovery on any active lane ends training as failed. Any other failing read is followed by an adjustment and a commit.
- R7: Every pass ends with a write of 0 to 0x102. If the pass failed at the fast rate, the block switches to the slow rate and restarts from R2. A failure at the slow rate is final.
- R8: At most one sideband request is outstanding. `sb_req`, `sb_addr` and `sb_write` hold until `sb_done`. An `sb_done` with `sb_err` set counts as a failure of the current phase, which then goes on to the R7 end step.
- R9: `done` is a one-cycle pulse at the end of training. `trained` rises only with `done`, is 1 only on success, and holds until the next `start`.
- R10: `tx_pattern` follows the last pattern written and is never 3. `tx_drive` equals the last committed drive byte. `tx_fast` shows the rate currently in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training (sampled while idle) |
| cap_fast | input | 1 | Begin at the fast rate |
| cap_lanes | input | 3 | Lane count to train (1, 2 or 4) |
| sink_rev | input | 8 | Receiver revision byte |
| sink_enh | input | 1 | Receiver supports enhanced framing |
| max_swing | input | 2 | Highest usable swing level |
| max_pre | input | 2 | Highest usable pre-emphasis level |
| sb_req | output | 1 | Sideband request pending |
| sb_write | output | 1 | 1 = write, 0 = read |
| sb_addr | output | ADDR_W | Receiver register address |
| sb_len | output | 3 | Transfer length in bytes |
| sb_wdata | output | 32 | Write bytes, byte 0 in [7:0] |
| sb_rdata | input | 24 | Read bytes, byte 0 in [7:0], valid with `sb_done` |
| sb_done | input | 1 | Request finished |
| sb_err | input | 1 | Request failed (with `sb_done`) |
| hp_irq_mask | output | 1 | Mask hot-plug interrupt while training |
| tx_pattern | output | 2 | Local training pattern |
| tx_drive | output | 6 | Local committed drive byte |
| tx_fast | output | 1 | Local rate: 1 = fast |
| done | output | 1 | Training finished pulse |
| trained | output | 1 | Result of last training |

## Verification
The bench builds the block with `CR_WAIT` = 4 and `EQ_WAIT` = 6 and keeps the default try limits of 5 and 6, so one full fast-then-slow run fits in a few hundred cycles. At these settings the bench can drive every exit path within one run of a few thousand cycles: try exhaustion in both phases, the swing-limit abort, the clamped pre-emphasis, the lost clock recovery, an injected sideband error and the rate fallback. The sideband model answers after a two-cycle latency, so every request also exercises the hold-until-done rule.

// File: rtl/lt_pkg.sv
package lt_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_RATE, S_LANES, S_CR_PAT, S_CR_COMMIT, S_CR_WAIT, S_CR_STAT,
      S_CR_ADJ, S_EQ_PAT, S_EQ_WAIT, S_EQ_STAT, S_EQ_ADJ, S_EQ_COMMIT,
      S_STOP, S_FIN
   } lt_state_e;

   // receiver register addresses
   localparam logic [19:0] A_RATE  = 20'h00100;
   localparam logic [19:0] A_LANES = 20'h00101;
   localparam logic [19:0] A_PAT   = 20'h00102;
   localparam logic [19:0] A_LSET  = 20'h00103;
   localparam logic [19:0] A_STAT  = 20'h00202;
   localparam logic [19:0] A_ADJ   = 20'h00206;

   localparam int LANES = 4;

endpackage

// File: rtl/lt_timer.sv
module lt_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm,
   input  logic [W-1:0] len,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (arm)           cnt_q <= len;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/lt_lane_stat.sv
module lt_lane_stat
   import lt_pkg::*;
(
   input  logic [23:0]      rdata,
   input  logic [LANES-1:0] lane_mask,
   output logic             cr_all,
   output logic             eq_all,
   output logic             aligned
);
   logic [LANES-1:0] cr_ok;
   logic [LANES-1:0] eq_ok;
   logic             unused_hi;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [3:0] nib;
      assign nib      = rdata[4*k +: 4];
      assign cr_ok[k] = !lane_mask[k] || nib[0];
      assign eq_ok[k] = !lane_mask[k] || (nib[2:0] == 3'b111);
   end

   assign cr_all    = &cr_ok;
   assign eq_all    = &eq_ok;
   assign aligned   = rdata[16];
   assign unused_hi = ^rdata[23:17];
endmodule

// File: rtl/lt_adjust.sv
module lt_adjust
   import lt_pkg::*;
(
   input  logic [15:0]      req,
   input  logic [LANES-1:0] lane_mask,
   input  logic [1:0]       max_swing,
   input  logic [1:0]       max_pre,
   output logic [5:0]       cfg
);
   logic [1:0] sw_l [LANES];
   logic [1:0] pr_l [LANES];
   logic [1:0] sw_m, pr_m;
   logic [2:0] sw_f, pr_f;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign sw_l[k] = lane_mask[k] ? req[4*k +: 2]     : 2'd0;
      assign pr_l[k] = lane_mask[k] ? req[4*k + 2 +: 2] : 2'd0;
   end

   always_comb begin
      sw_m = 2'd0;
      pr_m = 2'd0;
      for (int k = 0; k < LANES; k++) begin
         if (sw_l[k] > sw_m) sw_m = sw_l[k];
         if (pr_l[k] > pr_m) pr_m = pr_l[k];
      end
      sw_f = (sw_m >= max_swing) ? {1'b1, max_swing} : {1'b0, sw_m};
      pr_f = (pr_m >= max_pre)   ? {1'b1, max_pre}   : {1'b0, pr_m};
      cfg  = {pr_f, sw_f};
   end
endmodule

// File: rtl/lt_seq.sv
module lt_seq
   import lt_pkg::*;
#(
   parameter int          ADDR_W   = 20,
   parameter int          CR_WAIT  = 10000,
   parameter int          EQ_WAIT  = 40000,
   parameter int          CR_TRIES = 5,
   parameter int          EQ_TRIES = 6,
   parameter logic [7:0]  RATE_HI  = 8'h0A,
   parameter logic [7:0]  RATE_LO  = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cap_fast,
   input  logic [2:0]        cap_lanes,
   input  logic [7:0]        sink_rev,
   input  logic              sink_enh,
   input  logic [1:0]        max_swing,
   input  logic [1:0]        max_pre,
   output logic              sb_req,
   output logic              sb_write,
   output logic [ADDR_W-1:0] sb_addr,
   output logic [2:0]        sb_len,
   output logic [31:0]       sb_wdata,
   input  logic [23:0]       sb_rdata,
   input  logic              sb_done,
   input  logic              sb_err,
   output logic              hp_irq_mask,
   output logic [1:0]        tx_pattern,
   output logic [5:0]        tx_drive,
   output logic              tx_fast,
   output logic              done,
   output logic              trained
);
   localparam int WMAX = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
   localparam int TW   = $clog2(WMAX + 1);
   localparam int CTW  = $clog2(CR_TRIES + 1);
   localparam int ETW  = $clog2(EQ_TRIES + 1);

   if (ADDR_W < 10 || CR_WAIT < 1 || EQ_WAIT < 1 || CR_TRIES < 1 || EQ_TRIES < 1) begin : g_bad
      $error("lt_seq: illegal parameter set");
   end

   lt_state_e        state_q;
   logic [LANES-1:0] lmask_q;
   logic [2:0]       lnum_q;
   logic             enh_q;
   logic [1:0]       msw_q, mpre_q;
   logic [5:0]       cfg_q;
   logic [1:0]       prev_sw_q;
   logic             prev_ok_q;
   logic [CTW-1:0]   tries_q;
   logic [ETW-1:0]   eqt_q;
   logic             ok_q;

   logic             cr_all, eq_all, aligned;
   logic [5:0]       adj_cfg;
   logic             tmr_arm, tmr_exp;
   logic [TW-1:0]    tmr_len;
   logic [31:0]      lset_word;
   logic [CTW-1:0]   try_next;

   lt_lane_stat u_stat (.rdata(sb_rdata), .lane_mask(lmask_q),
                        .cr_all(cr_all), .eq_all(eq_all), .aligned(aligned));

   lt_adjust u_adj (.req(sb_rdata[15:0]), .lane_mask(lmask_q),
                    .max_swing(msw_q), .max_pre(mpre_q), .cfg(adj_cfg));

   lt_timer #(.W(TW)) u_tmr (.clk(clk), .rst_n(rst_n), .arm(tmr_arm),
                             .len(tmr_len), .expired(tmr_exp));

   for (genvar k = 0; k < LANES; k++) begin : g_lset
      assign lset_word[8*k +: 8] = lmask_q[k] ? {2'b00, cfg_q} : 8'h00;
   end

   assign try_next = (prev_ok_q && prev_sw_q == cfg_q[1:0]) ? tries_q + 1'b1 : CTW'(1);
   assign tmr_arm  = sb_done && !sb_err &&
                     (state_q == S_CR_COMMIT || state_q == S_EQ_PAT || state_q == S_EQ_COMMIT);
   assign tmr_len  = (state_q == S_CR_COMMIT) ? TW'(CR_WAIT) : TW'(EQ_WAIT);

   assign done        = (state_q == S_FIN);
   assign hp_irq_mask = (state_q != S_IDLE) && (state_q != S_FIN);

   // sideband request decode
   always_comb begin
      sb_req   = 1'b1;
      sb_write = 1'b1;
      sb_addr  = '0;
      sb_len   = 3'd1;
      sb_wdata = '0;
      unique case (state_q)
         S_RATE:  begin sb_addr = ADDR_W'(A_RATE);  sb_wdata[7:0] = tx_fast ? RATE_HI : RATE_LO; end
         S_LANES: begin sb_addr = ADDR_W'(A_LANES); sb_wdata[7:0] = {enh_q, 4'b0000, lnum_q}; end
         S_CR_PAT: begin sb_addr = ADDR_W'(A_PAT);  sb_wdata[7:0] = 8'd1; end
         S_EQ_PAT: begin sb_addr = ADDR_W'(A_PAT);  sb_wdata[7:0] = 8'd2; end
         S_STOP:   begin sb_addr = ADDR_W'(A_PAT);  sb_wdata[7:0] = 8'd0; end
         S_CR_COMMIT, S_EQ_COMMIT: begin
            sb_addr = ADDR_W'(A_LSET); sb_len = 3'd4; sb_wdata = lset_word;
         end
         S_CR_STAT: begin sb_write = 1'b0; sb_addr = ADDR_W'(A_STAT); sb_len = 3'd2; end
         S_EQ_STAT: begin sb_write = 1'b0; sb_addr = ADDR_W'(A_STAT); sb_len = 3'd3; end
         S_CR_ADJ, S_EQ_ADJ: begin sb_write = 1'b0; sb_addr = ADDR_W'(A_ADJ); sb_len = 3'd2; end
         default: begin sb_req = 1'b0; sb_write = 1'b0; sb_len = 3'd0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         lmask_q    <= '0;
         lnum_q     <= '0;
         enh_q      <= 1'b0;
         msw_q      <= '0;
         mpre_q     <= '0;
         cfg_q      <= '0;
         prev_sw_q  <= '0;
         prev_ok_q  <= 1'b0;
         tries_q    <= '0;
         eqt_q      <= '0;
         ok_q       <= 1'b0;
         tx_pattern <= 2'd0;
         tx_drive   <= '0;
         tx_fast    <= 1'b0;
         trained    <= 1'b0;
      end else begin
         unique case (state_q)
            S_IDLE: if (start) begin
               tx_fast <= cap_fast;
               enh_q   <= sink_enh && (sink_rev >= 8'h11);
               msw_q   <= max_swing;
               mpre_q  <= max_pre;
               trained <= 1'b0;
               ok_q    <= 1'b0;
               unique case (cap_lanes)
                  3'd1:    begin lmask_q <= 4'b0001; lnum_q <= 3'd1; end
                  3'd2:    begin lmask_q <= 4'b0011; lnum_q <= 3'd2; end
                  default: begin lmask_q <= 4'b1111; lnum_q <= 3'd4; end
               endcase
               state_q <= S_RATE;
            end
            S_RATE:  if (sb_done) state_q <= sb_err ? S_STOP : S_LANES;
            S_LANES: if (sb_done) state_q <= sb_err ? S_STOP : S_CR_PAT;
            S_CR_PAT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin
                  tx_pattern <= 2'd1;
                  cfg_q      <= '0;
                  prev_ok_q  <= 1'b0;
                  tries_q    <= '0;
                  state_q    <= S_CR_COMMIT;
               end
            end
            S_CR_COMMIT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin tx_drive <= cfg_q; state_q <= S_CR_WAIT; end
            end
            S_CR_WAIT: if (tmr_exp) state_q <= S_CR_STAT;
            S_CR_STAT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin
                  tries_q   <= try_next;
                  prev_sw_q <= cfg_q[1:0];
                  prev_ok_q <= 1'b1;
                  if (cr_all)                                        state_q <= S_EQ_PAT;
                  else if (cfg_q[2] || try_next == CTW'(CR_TRIES))   state_q <= S_STOP;
                  else                                               state_q <= S_CR_ADJ;
               end
            end
            S_CR_ADJ: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin cfg_q <= adj_cfg; state_q <= S_CR_COMMIT; end
            end
            S_EQ_PAT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin tx_pattern <= 2'd2; eqt_q <= '0; state_q <= S_EQ_WAIT; end
            end
            S_EQ_WAIT: if (tmr_exp) state_q <= S_EQ_STAT;
            S_EQ_STAT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else if (aligned && eq_all) begin ok_q <= 1'b1; state_q <= S_STOP; end
               else if (!cr_all || eqt_q == ETW'(EQ_TRIES - 1)) state_q <= S_STOP;
               else begin eqt_q <= eqt_q + 1'b1; state_q <= S_EQ_ADJ; end
            end
            S_EQ_ADJ: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin cfg_q <= adj_cfg; state_q <= S_EQ_COMMIT; end
            end
            S_EQ_COMMIT: if (sb_done) begin
               if (sb_err) state_q <= S_STOP;
               else begin tx_drive <= cfg_q; state_q <= S_EQ_WAIT; end
            end
            S_STOP: if (sb_done) begin
               tx_pattern <= 2'd0;
               if (!sb_err && !ok_q && tx_fast) begin
                  tx_fast <= 1'b0;
                  state_q <= S_RATE;
               end else begin
                  trained <= ok_q && !sb_err;
                  state_q <= S_FIN;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sb_req,
   input logic              sb_write,
   input logic [ADDR_W-1:0] sb_addr,
   input logic              sb_done,
   input logic              hp_irq_mask,
   input logic [1:0]        tx_pattern,
   input logic              done,
   input logic              trained
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req && !sb_done |=> sb_req);                                   // R8
   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req && !sb_done |=> $stable(sb_addr) && $stable(sb_write));    // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                  // R9
   AST_TRAINED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trained) |-> done);                                         // R9
   AST_MASK_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req |-> hp_irq_mask);                                          // R1
   AST_DONE_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !hp_irq_mask && !sb_req);                                // R1
   AST_PAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pattern != 2'b11);                                             // R10
endmodule

bind lt_seq lt_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sb_req(sb_req), .sb_write(sb_write),
   .sb_addr(sb_addr), .sb_done(sb_done), .hp_irq_mask(hp_irq_mask),
   .tx_pattern(tx_pattern), .done(done), .trained(trained)
);

// File: tb/sim_lt_seq.sv
`timescale 1ns/1ps
module sim_lt_seq;
   localparam int AW  = 20;
   localparam int LAT = 2;

   typedef struct packed {
      logic       fast;
      logic [2:0] lanes;
      logic [7:0] rev;
      logic       enh;
      logic [1:0] msw;
      logic [1:0] mpre;
      logic [7:0] cr_need;
      logic [7:0] eq_need;
      logic [15:0] adj;
      logic       fail_hi;
      logic       cr_lose;
      logic       err_cr;
      logic       e_trained;
      logic [7:0] e_rate;
      logic [7:0] e_lanes;
      logic [7:0] e_crn;
      logic [7:0] e_eqn;
      logic [7:0] e_cfg;
      logic [3:0] e_ratew;
   } row_t;

   localparam row_t ROWS [0:8] = '{
      '{1'b1,3'd4,8'h12,1'b1,2'd3,2'd3,8'd1, 8'd1, 16'h0000,1'b0,1'b0,1'b0, 1'b1,8'h0A,8'h84,8'd1,8'd1,8'h00,4'd1},
      '{1'b1,3'd2,8'h10,1'b1,2'd3,2'd3,8'd3, 8'd1, 16'hFF61,1'b0,1'b0,1'b0, 1'b1,8'h0A,8'h02,8'd3,8'd1,8'h0A,4'd1},
      '{1'b0,3'd1,8'h11,1'b0,2'd3,2'd3,8'd99,8'd1, 16'h0000,1'b0,1'b0,1'b0, 1'b0,8'h06,8'h01,8'd5,8'd0,8'h00,4'd1},
      '{1'b0,3'd1,8'h11,1'b0,2'd2,2'd3,8'd99,8'd1, 16'h0003,1'b0,1'b0,1'b0, 1'b0,8'h06,8'h01,8'd2,8'd0,8'h06,4'd1},
      '{1'b1,3'd4,8'h14,1'b1,2'd3,2'd3,8'd1, 8'd1, 16'h0000,1'b1,1'b0,1'b0, 1'b1,8'h06,8'h84,8'd6,8'd1,8'h00,4'd2},
      '{1'b0,3'd2,8'h11,1'b1,2'd3,2'd3,8'd1, 8'd99,16'h0000,1'b0,1'b0,1'b0, 1'b0,8'h06,8'h82,8'd1,8'd6,8'h00,4'd1},
      '{1'b0,3'd1,8'h11,1'b0,2'd3,2'd1,8'd2, 8'd1, 16'h0009,1'b0,1'b0,1'b0, 1'b1,8'h06,8'h01,8'd2,8'd1,8'h29,4'd1},
      '{1'b0,3'd4,8'h11,1'b0,2'd3,2'd3,8'd1, 8'd1, 16'h0000,1'b0,1'b1,1'b0, 1'b0,8'h06,8'h04,8'd1,8'd1,8'h00,4'd1},
      '{1'b0,3'd4,8'h11,1'b0,2'd3,2'd3,8'd1, 8'd1, 16'h0000,1'b0,1'b0,1'b1, 1'b0,8'h06,8'h04,8'd1,8'd0,8'h00,4'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, cap_fast = 1'b0, sink_enh = 1'b0;
   logic [2:0] cap_lanes = 3'd1;
   logic [7:0] sink_rev = 8'h00;
   logic [1:0] max_swing = 2'd3, max_pre = 2'd3;
   logic sb_req, sb_write, sb_done, sb_err;
   logic [AW-1:0] sb_addr;
   logic [2:0] sb_len;
   logic [31:0] sb_wdata;
   logic [23:0] sb_rdata;
   logic hp_irq_mask, tx_fast, done, trained;
   logic [1:0] tx_pattern;
   logic [5:0] tx_drive;

   always #10 clk = ~clk;

   lt_seq #(.ADDR_W(AW), .CR_WAIT(4), .EQ_WAIT(6)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .cap_fast(cap_fast),
      .cap_lanes(cap_lanes), .sink_rev(sink_rev), .sink_enh(sink_enh),
      .max_swing(max_swing), .max_pre(max_pre), .sb_req(sb_req),
      .sb_write(sb_write), .sb_addr(sb_addr), .sb_len(sb_len),
      .sb_wdata(sb_wdata), .sb_rdata(sb_rdata), .sb_done(sb_done),
      .sb_err(sb_err), .hp_irq_mask(hp_irq_mask), .tx_pattern(tx_pattern),
      .tx_drive(tx_drive), .tx_fast(tx_fast), .done(done), .trained(trained));

   // sideband responder scenario
   row_t cur;
   logic clr = 1'b0;
   logic inflight;
   int   lat_cnt;
   logic [7:0] m_rate, m_lanes, m_pat, m_cfg, m_first_cfg;
   logic       m_seen_cfg;
   logic [AW-1:0] m_prev;
   int m_ratew, m_crn, m_eqn, m_crph, m_eqph, m_seq_bad, m_proto_bad;

   always @(posedge clk) begin
      if (!rst_n || clr) begin
         inflight <= 1'b0; lat_cnt <= 0; sb_done <= 1'b0; sb_err <= 1'b0;
         sb_rdata <= '0; m_rate <= 8'hFF; m_lanes <= 8'hFF; m_pat <= 8'hFF;
         m_cfg <= 8'hFF; m_first_cfg <= 8'hFF; m_seen_cfg <= 1'b0; m_prev <= '0;
         m_ratew <= 0; m_crn <= 0; m_eqn <= 0; m_crph <= 0; m_eqph <= 0;
         m_seq_bad <= 0; m_proto_bad <= 0;
      end else begin
         sb_done <= 1'b0;
         sb_err  <= 1'b0;
         if (inflight) begin
            if (!sb_req) m_proto_bad <= m_proto_bad + 1;
            if (lat_cnt == 0) begin
               inflight <= 1'b0;
               sb_done  <= 1'b1;
               m_prev   <= sb_addr;
               case (sb_addr)
                  20'h00100: begin m_rate <= sb_wdata[7:0]; m_ratew <= m_ratew + 1; end
                  20'h00101: begin
                     m_lanes <= sb_wdata[7:0];
                     if (m_prev != 20'h00100) m_seq_bad <= m_seq_bad + 1;
                  end
                  20'h00102: begin
                     m_pat <= sb_wdata[7:0];
                     if (sb_wdata[7:0] == 8'd1) m_crph <= 0;
                     if (sb_wdata[7:0] == 8'd2) m_eqph <= 0;
                  end
                  20'h00103: begin
                     m_cfg <= sb_wdata[7:0];
                     if (!m_seen_cfg) begin m_first_cfg <= sb_wdata[7:0]; m_seen_cfg <= 1'b1; end
                  end
                  20'h00202: begin
                     if (sb_len == 3'd2) begin
                        m_crn  <= m_crn + 1;
                        m_crph <= m_crph + 1;
                        sb_err <= cur.err_cr;
                        sb_rdata <= ((m_crph + 1 >= int'(cur.cr_need)) &&
                                     !(cur.fail_hi && m_rate == 8'h0A)) ? 24'h001111 : 24'h000000;
                     end else begin
                        m_eqn  <= m_eqn + 1;
                        m_eqph <= m_eqph + 1;
                        sb_rdata <= cur.cr_lose ? 24'h000000 :
                                    (m_eqph + 1 >= int'(cur.eq_need)) ? 24'h017777 : 24'h001111;
                     end
                  end
                  20'h00206: sb_rdata <= {8'h00, cur.adj};
                  default: ;
               endcase
            end else lat_cnt <= lat_cnt - 1;
         end else if (sb_req && !sb_done) begin
            inflight <= 1'b1;
            lat_cnt  <= LAT - 1;
         end
      end
   end

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic run_row(input row_t r, output bit timed_out);
      int w;
      @(negedge clk);
      cur = r; clr = 1'b1;
      cap_fast = r.fast; cap_lanes = r.lanes; sink_rev = r.rev; sink_enh = r.enh;
      max_swing = r.msw; max_pre = r.mpre;
      @(negedge clk);
      clr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R1 mask while training", {31'd0, hp_irq_mask}, 32'd1);
      w = 0;
      timed_out = 1'b0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
      if (!done) timed_out = 1'b1;
   endtask

   initial begin
      bit to;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset mask", {31'd0, hp_irq_mask}, 32'd0);
      chk("R1 reset req", {31'd0, sb_req}, 32'd0);
      chk("R9 reset done", {31'd0, done}, 32'd0);
      chk("R9 reset trained", {31'd0, trained}, 32'd0);
      chk("R10 reset pattern", {30'd0, tx_pattern}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i <= 8; i++) begin
         run_row(ROWS[i], to);
         if (to) chk("R9 watchdog done", 32'd0, 32'd1);
         chk("R9 trained", {31'd0, trained}, {31'd0, ROWS[i].e_trained});
         chk("R2 R7 rate code", {24'd0, m_rate}, {24'd0, ROWS[i].e_rate});
         chk("R2 lane byte", {24'd0, m_lanes}, {24'd0, ROWS[i].e_lanes});
         chk("R2 rate before lanes", m_seq_bad, 0);
         chk("R3 R4 cr reads", m_crn, {24'd0, ROWS[i].e_crn});
         chk("R6 eq reads", m_eqn, {24'd0, ROWS[i].e_eqn});
         chk("R5 last drive", {24'd0, m_cfg}, {24'd0, ROWS[i].e_cfg});
         chk("R3 first drive zero", {24'd0, m_first_cfg}, 32'd0);
         chk("R7 rate writes", m_ratew, {28'd0, ROWS[i].e_ratew});
         chk("R7 final pattern off", {24'd0, m_pat}, 32'd0);
         chk("R8 one outstanding", m_proto_bad, 0);
         chk("R10 tx_drive", {26'd0, tx_drive}, {24'd0, ROWS[i].e_cfg});
         chk("R10 tx_fast", {31'd0, tx_fast}, {31'd0, ROWS[i].e_rate == 8'h0A});
         @(negedge clk);
         chk("R9 done pulse", {31'd0, done}, 32'd0);
         chk("R1 unmask after", {31'd0, hp_irq_mask}, 32'd0);
         if (i == 8) chk("R8 error ends phase", {31'd0, trained}, 32'd0);
      end

      // R9 trained holds until next start
      run_row(ROWS[0], to);
      if (to) chk("R9 watchdog done", 32'd0, 32'd1);
      repeat (10) @(negedge clk);
      chk("R9 trained held", {31'd0, trained}, 32'd1);
      chk("R10 pattern off idle", {30'd0, tx_pattern}, 32'd0);
      @(negedge clk);
      cur = ROWS[2]; clr = 1'b1;
      cap_fast = 1'b0; cap_lanes = 3'd1; max_swing = 2'd3; max_pre = 2'd3;
      @(negedge clk);
      clr = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 trained cleared at start", {31'd0, trained}, 32'd0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait (cyc >= 150000);
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule